// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt request lines. It masks each line with a per-source enable and steers it to one of two processor inputs: a fast-interrupt output or a normal-interrupt output. Software can also force any source active through a software request register. A forced request behaves the same as a raw line.

A set of numbered vector slots binds individual sources to handler addresses. Each slot stores a source number, a slot-enable flag and a 32-bit handler address. The slot index sets the priority, and index 0 is the highest. When the processor reads the vector register, it gets the handler address of the highest-priority enabled slot whose source is active and routed to the normal output. If no slot matches, the read returns a default address. The value read stays frozen until software writes the vector register, which acknowledges the interrupt and re-arms resolution.

All registers are 32-bit words on a simple register bus. Writes take effect on the clock edge where `wrEn` is high. `rdData` follows `busAddr` combinationally, and `rdEn` marks a read transaction.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Writing to the enable-set register (0x010) sets every enable bit where the written data is 1. Writing to the enable-clear register (0x014) clears every enable bit where the data is 1. Zero data bits change nothing. Reading 0x010 returns the enable register.
- R2: The steering register (0x00C, read/write) routes each source. A 1 routes it to `fiqOut` and a 0 routes it to `irqOut`. Each output is the OR of the active sources in its group.
- R3: A source is active when its line or its software request is 1 and its enable bit is 1. A source that is not enabled drives neither output.
- R4: Writing 1s to software-set (0x018) forces the matching sources. Writing 1s to software-clear (0x01C) removes them. Zero bits change nothing. Reading 0x018 returns the software request register.
- R5: Slot i has a handler-address register at 0x100+4·i (32 bits, read/write) and a control register at 0x200+4·i. The control register keeps bits 4:0 as the source number and bit 5 as the slot enable, and reads 0 in bits 31:6.
- R6: A read of the vector register (0x030) returns the address of the lowest-index enabled slot whose source is active and routed to the normal output. The value reflects register and line state as of the previous clock edge.
- R7: When no slot qualifies, the vector register reads the default address (0x034, read/write). This covers a bound source that is routed to the fast output.
- R8: After a read of 0x030, the vector value stays frozen whatever the sources do. Any write to 0x030 releases it, and later reads track resolution again.
- R9: Status reads return (lines|software) at 0x008, the active normal-group sources at 0x000 and the active fast-group sources at 0x004.
- R10: After reset, the enable, steering, software, default and all slot registers are zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 32 | Level-sensitive request lines, one per source |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (freezes the vector on 0x030) |
| busAddr | input | 10 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `busAddr` |
| fiqOut | output | 1 | Fast-interrupt request |
| irqOut | output | 1 | Normal-interrupt request |

## Verification
The bench targets priority between two qualifying slots, where a reversed scan would return the higher-index handler. It checks that a bound source steered to the fast output falls back to the default address, which a resolver ignoring the steering bit would get wrong. Zero-data writes to the set and clear registers confirm that nothing changes, which catches a design that overwrites instead of OR-ing or AND-ing. The freeze-and-release sequence on the vector register catches a design that keeps tracking after a read or never re-arms after the acknowledge write.

// File: rtl/vic_pkg.sv
package vicPkg;
  localparam int DATA_W   = 32;
  localparam int NSRC     = 32;
  localparam int SRC_W    = 5;
  localparam int ADDR_W   = 10;
  localparam int SLOTIX_W = 5;

  localparam logic [ADDR_W-1:0] A_STAT_IRQ = 10'h000;
  localparam logic [ADDR_W-1:0] A_STAT_FIQ = 10'h004;
  localparam logic [ADDR_W-1:0] A_STAT_RAW = 10'h008;
  localparam logic [ADDR_W-1:0] A_STEER    = 10'h00C;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 10'h010;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 10'h014;
  localparam logic [ADDR_W-1:0] A_SW_SET   = 10'h018;
  localparam logic [ADDR_W-1:0] A_SW_CLR   = 10'h01C;
  localparam logic [ADDR_W-1:0] A_VECT     = 10'h030;
  localparam logic [ADDR_W-1:0] A_DFLT     = 10'h034;
  localparam logic [1:0]        REGION_SADDR = 2'b01;
  localparam logic [1:0]        REGION_SCTL  = 2'b10;

  typedef struct packed {
    logic                enSet;
    logic                enClr;
    logic                steerWr;
    logic                swSet;
    logic                swClr;
    logic                dfltWr;
    logic                vectAck;
    logic                vectRead;
    logic                slotAddrWr;
    logic                slotCtlWr;
    logic [SLOTIX_W-1:0] slotIdx;
  } vicStrobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vicPkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output vicStrobe_t        strb
);
  logic aligned;
  logic inSlotArea;
  logic [SLOTIX_W-1:0] idx;

  assign aligned    = (busAddr[1:0] == 2'b00);
  assign idx        = busAddr[6:2];
  assign inSlotArea = aligned && !busAddr[7] && (int'(idx) < NUM_SLOTS);

  always_comb begin
    strb            = '0;
    strb.slotIdx    = idx;
    strb.enSet      = wrEn && (busAddr == A_EN_SET);
    strb.enClr      = wrEn && (busAddr == A_EN_CLR);
    strb.steerWr    = wrEn && (busAddr == A_STEER);
    strb.swSet      = wrEn && (busAddr == A_SW_SET);
    strb.swClr      = wrEn && (busAddr == A_SW_CLR);
    strb.dfltWr     = wrEn && (busAddr == A_DFLT);
    strb.vectAck    = wrEn && (busAddr == A_VECT);
    strb.vectRead   = rdEn && !wrEn && (busAddr == A_VECT);
    strb.slotAddrWr = wrEn && inSlotArea && (busAddr[9:8] == REGION_SADDR);
    strb.slotCtlWr  = wrEn && inSlotArea && (busAddr[9:8] == REGION_SCTL);
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vicPkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  vicStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NSRC-1:0]   irqLines,
  output logic [DATA_W-1:0] rdData,
  output logic              fiqOut,
  output logic              irqOut
);
  localparam int CTL_W = SRC_W + 1;

  logic [NSRC-1:0]   enableReg, steerReg, softReg;
  logic [DATA_W-1:0] dfltAddr, vectCur, winAddr;
  logic [DATA_W-1:0] slotAddr [NUM_SLOTS];
  logic [CTL_W-1:0]  slotCtl  [NUM_SLOTS];
  logic              held;
  logic [NSRC-1:0]   rawReq, actReq, fastAct, normAct;

  assign rawReq  = irqLines | softReg;
  assign actReq  = rawReq & enableReg;
  assign fastAct = actReq & steerReg;
  assign normAct = actReq & ~steerReg;
  assign fiqOut  = |fastAct;
  assign irqOut  = |normAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      steerReg  <= '0;
      softReg   <= '0;
      dfltAddr  <= '0;
    end else begin
      if (strb.enSet)   enableReg <= enableReg | wrData;
      if (strb.enClr)   enableReg <= enableReg & ~wrData;
      if (strb.steerWr) steerReg  <= wrData;
      if (strb.swSet)   softReg   <= softReg | wrData;
      if (strb.swClr)   softReg   <= softReg & ~wrData;
      if (strb.dfltWr)  dfltAddr  <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[i] <= '0;
        slotCtl[i]  <= '0;
      end else begin
        if (strb.slotAddrWr && (int'(strb.slotIdx) == i)) slotAddr[i] <= wrData;
        if (strb.slotCtlWr  && (int'(strb.slotIdx) == i)) slotCtl[i]  <= wrData[CTL_W-1:0];
      end
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    winAddr = dfltAddr;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slotCtl[i][SRC_W] && normAct[slotCtl[i][SRC_W-1:0]]) winAddr = slotAddr[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held    <= 1'b0;
      vectCur <= '0;
    end else begin
      if (!held) vectCur <= winAddr;
      if (strb.vectAck)       held <= 1'b0;
      else if (strb.vectRead) held <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (busAddr)
      A_STAT_IRQ: rdData = normAct;
      A_STAT_FIQ: rdData = fastAct;
      A_STAT_RAW: rdData = rawReq;
      A_STEER:    rdData = steerReg;
      A_EN_SET:   rdData = enableReg;
      A_SW_SET:   rdData = softReg;
      A_VECT:     rdData = vectCur;
      A_DFLT:     rdData = dfltAddr;
      default: begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (busAddr[1:0] == 2'b00 && !busAddr[7] && int'(busAddr[6:2]) == i) begin
            if (busAddr[9:8] == REGION_SADDR) rdData = slotAddr[i];
            if (busAddr[9:8] == REGION_SCTL)  rdData = DATA_W'(slotCtl[i]);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vicPkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   irqLines,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              fiqOut,
  output logic              irqOut
);
  vicStrobe_t strb;

  vic_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .busAddr(busAddr), .strb(strb)
  );

  vic_datapath #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .wrData(wrData),
    .irqLines(irqLines), .rdData(rdData), .fiqOut(fiqOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vicPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              fiqOut,
  input logic              irqOut,
  input logic [NSRC-1:0]   enableReg,
  input logic [NSRC-1:0]   softReg,
  input logic              held,
  input logic [DATA_W-1:0] vectCur
);
  a_r1_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == A_EN_SET) |=> ((enableReg & $past(wrData)) == $past(wrData)));

  a_r1_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == A_EN_CLR) |=> ((enableReg & $past(wrData)) == '0));

  a_r4_soft_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == A_SW_SET) |=> ((softReg & $past(wrData)) == $past(wrData)));

  a_r4_soft_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == A_SW_CLR) |=> ((softReg & $past(wrData)) == '0));

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> (!fiqOut && !irqOut));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    held |=> $stable(vectCur));

  a_r8_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == A_VECT) |=> !held);
endmodule

bind irq_vector_ctrl vic_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .busAddr(busAddr), .wrData(wrData),
  .fiqOut(fiqOut), .irqOut(irqOut), .enableReg(u_dp.enableReg),
  .softReg(u_dp.softReg), .held(u_dp.held), .vectCur(u_dp.vectCur)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  import vicPkg::*;
  localparam int NS = 16;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] wrData = '0, irqLines = '0;
  logic [31:0] rdData;
  logic fiqOut, irqOut;

  irq_vector_ctrl #(.NUM_SLOTS(NS)) dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .wrEn(wrEn), .rdEn(rdEn),
    .busAddr(busAddr), .wrData(wrData), .rdData(rdData), .fiqOut(fiqOut), .irqOut(irqOut)
  );

  logic [31:0] mEn = '0, mSel = '0, mSoft = '0, mDflt = '0, mHeldVal = '0;
  logic [31:0] mSA [NS];
  logic [5:0]  mSC [NS];
  bit mHeld = 0;
  int nChk = 0, nFail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] actv();
    return (irqLines | mSoft) & mEn;
  endfunction

  function automatic logic [31:0] expWin();
    logic [31:0] n = actv() & ~mSel;
    for (int i = 0; i < NS; i++)
      if (mSC[i][5] && n[mSC[i][4:0]]) return mSA[i];
    return mDflt;
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; busAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      A_EN_SET: mEn   = mEn | d;
      A_EN_CLR: mEn   = mEn & ~d;
      A_STEER:  mSel  = d;
      A_SW_SET: mSoft = mSoft | d;
      A_SW_CLR: mSoft = mSoft & ~d;
      A_DFLT:   mDflt = d;
      A_VECT:   mHeld = 0;
      default: begin
        if (a[9:8] == REGION_SADDR) mSA[a[6:2]] = d;
        if (a[9:8] == REGION_SCTL)  mSC[a[6:2]] = d[5:0];
      end
    endcase
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkOuts();
    logic [31:0] act;
    @(negedge clk); #1;
    act = actv();
    check("R2 fiqOut", {31'b0, fiqOut}, {31'b0, |(act & mSel)});
    check("R3 irqOut", {31'b0, irqOut}, {31'b0, |(act & ~mSel)});
  endtask

  task automatic checkStatus();
    logic [31:0] d;
    rd(A_STAT_RAW, d); check("R9 raw", d, irqLines | mSoft);
    rd(A_STAT_IRQ, d); check("R9 irq status", d, actv() & ~mSel);
    rd(A_STAT_FIQ, d); check("R9 fiq status", d, actv() & mSel);
  endtask

  task automatic checkVect(input string req);
    logic [31:0] d, e;
    @(posedge clk);
    e = mHeld ? mHeldVal : expWin();
    rd(A_VECT, d);
    check(req, d, e);
    if (!mHeld) begin mHeld = 1; mHeldVal = e; end
  endtask

  initial begin
    #(4 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin mSA[i] = '0; mSC[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    checkOuts();
    rd(A_EN_SET, d); check("R10 enable", d, 32'h0);
    rd(A_STEER, d);  check("R10 steer", d, 32'h0);
    rd(A_SW_SET, d); check("R10 soft", d, 32'h0);
    rd(12'h204, d);  check("R10 slot ctl", d, 32'h0);
    checkVect("R10 vector");
    wr(A_VECT, 0);

    // R1 set/clear with zero-bit writes
    wr(A_EN_SET, 32'h0000_00F0); wr(A_EN_SET, 32'h0);
    rd(A_EN_SET, d); check("R1 set", d, 32'h0000_00F0);
    wr(A_EN_CLR, 32'h0000_0010); wr(A_EN_CLR, 32'h0);
    rd(A_EN_SET, d); check("R1 clear", d, 32'h0000_00E0);

    // R4 soft set/clear
    wr(A_SW_SET, 32'h8000_0001); wr(A_SW_SET, 32'h0);
    rd(A_SW_SET, d); check("R4 soft set", d, 32'h8000_0001);
    wr(A_SW_CLR, 32'h0000_0001);
    rd(A_SW_SET, d); check("R4 soft clear", d, 32'h8000_0000);
    checkOuts();
    wr(A_EN_SET, 32'h8000_0000); checkOuts();
    wr(A_SW_CLR, 32'hFFFF_FFFF); wr(A_EN_CLR, 32'hFFFF_FFFF);

    // R5 slot register width
    wr(10'h10C, 32'hCAFE_0003); rd(10'h10C, d); check("R5 slot addr", d, 32'hCAFE_0003);
    wr(10'h20C, 32'hFFFF_FFE7); rd(10'h20C, d); check("R5 slot ctl", d, 32'h0000_0027);
    wr(10'h20C, 32'h0);

    // R6 priority, R7 default, R8 freeze/release
    wr(A_DFLT, 32'hDEAD_0000);
    wr(10'h108, 32'hAAAA_0002); wr(10'h208, 32'h27);
    wr(10'h114, 32'hBBBB_0005); wr(10'h214, 32'h29);
    wr(A_EN_SET, 32'h0000_0280);
    @(negedge clk) irqLines = 32'h0000_0280;
    checkVect("R6 lower index wins");
    @(negedge clk) irqLines = 32'h0000_0200;
    checkVect("R8 frozen after read");
    wr(A_VECT, 0);
    checkVect("R8 rearmed");
    wr(A_VECT, 0);
    wr(A_STEER, 32'h0000_0200);
    checkOuts();
    checkVect("R7 fast-steered falls back to default");
    wr(A_VECT, 0);
    wr(10'h214, 32'h09); wr(A_STEER, 0);
    checkVect("R7 disabled slot gives default");
    wr(A_VECT, 0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 9;
      int s  = $urandom % NS;
      case (op)
        0: wr(A_EN_SET, $urandom);
        1: wr(A_EN_CLR, $urandom);
        2: wr(A_STEER, $urandom & $urandom);
        3: wr(A_SW_SET, $urandom & $urandom & $urandom);
        4: wr(A_SW_CLR, $urandom);
        5: wr(10'h200 + 10'(s * 4), {26'($urandom), 1'($urandom), 5'($urandom)});
        6: wr(10'h100 + 10'(s * 4), $urandom);
        7: wr(A_DFLT, $urandom);
        default: begin @(negedge clk) irqLines = $urandom & $urandom; end
      endcase
      checkOuts();
      if (it % 5 == 0) checkStatus();
      if (it % 3 == 0) begin
        checkVect("R6 random vector");
        if (it % 2 == 0) wr(A_VECT, 0);
      end
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule